// File: doc/BRIEF.md
# Shader Configuration Register File

This block holds the configuration state of one programmable shader unit behind a 48-word, 32-bit register window. Most of the words are plain configuration registers, and their contents drive the shader core directly:

- a 16-bit set of boolean uniforms;
- four packed integer uniform vectors;
- the program entry offset;
- a 64-bit map from input attributes to registers;
- the index of the last input attribute;
- a 16-bit output mask.

Three upload channels load the unit's internal memories through a pointer word and eight aliased data words:

- float uniforms;
- program instruction words;
- swizzle-pattern entries.

Each data write lands at the pointer, and the pointer then advances on its own. Float uniforms arrive either as four 32-bit components or as four 24-bit components packed into three 32-bit words. The uniform index advances after each complete vector. The shader core reads the three memories through independent synchronous read ports.

Top module: `shcfg_regfile`

## Requirements
- R1: Word addresses are as follows:
  - 0x00 boolean uniforms;
  - 0x01..0x04 integer uniforms 0..3;
  - 0x05 entry offset;
  - 0x06 attribute map bits [31:0];
  - 0x07 attribute map bits [63:32];
  - 0x08 output mask;
  - 0x09 last attribute index;
  - 0x0A uniform setup;
  - 0x0B..0x12 uniform data;
  - 0x13 program pointer;
  - 0x14..0x1B program data;
  - 0x1C swizzle pointer;
  - 0x1D..0x24 swizzle data.

  All other addresses up to 0x2F are reserved. After reset every register, pointer and the read data are zero.
- R2: The boolean uniform register keeps bits [15:0] of a write, and a read returns them with bits [31:16] zero.
- R3: Each integer uniform word keeps all 32 bits, with component x in [7:0], y in [15:8], z in [23:16] and w in [31:24]. Integer uniform n appears on `int_unif[32n+31:32n]`.
- R4: The entry offset keeps 16 bits, the output mask keeps 16 bits and the last attribute index keeps 4 bits. Unused bits read as zero.
- R5: The two attribute map words read back in full and form `attr_map` with the word at 0x06 in the low half.
- R6: The uniform setup word holds the target index in bits [6:0] and the format in bit 31 (0 = 24-bit, 1 = 32-bit). A read returns the current index and the format. Writing the setup word discards any partially received vector.
- R7: In 32-bit format, four data writes complete one vector. The writes carry w, z, y and x in that order, and the vector is stored as {w,z,y,x} at the current index, after which the index increments.
- R8: In 24-bit format, three data writes form a 96-bit stream with the first write most significant. w is stream bits [95:72], z is [71:48], y is [47:24] and x is [23:0]. Each component is stored zero-extended to 32 bits. The index wraps from 127 to 0.
- R9: Any of the eight data addresses of a channel acts identically.
- R10: A program data write stores the word at the pointer modulo 512, then the 32-bit pointer increments by one. The pointer reads back its full value.
- R11: A swizzle data write stores the entry at the pointer modulo 128, then the 32-bit pointer increments by one.
- R12: Data addresses and reserved addresses read as zero. Writes to reserved addresses change nothing.
- R13: Bus read data and all three core read ports return their value one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 6 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bool_unif | output | 16 | Boolean uniforms |
| int_unif | output | 128 | Four integer uniform words |
| entry_off | output | 16 | Program entry offset |
| attr_map | output | 64 | Attribute-to-register map |
| attr_last | output | 4 | Index of last input attribute |
| out_mask | output | 16 | Output register mask |
| unif_raddr | input | 7 | Float uniform read index |
| unif_rdata | output | 128 | Float uniform vector {w,z,y,x} |
| prog_raddr | input | 9 | Program read address |
| prog_rdata | output | 32 | Program word |
| swz_raddr | input | 7 | Swizzle read address |
| swz_rdata | output | 32 | Swizzle entry |

## Verification
A register write takes effect at the clock edge that samples it. A configuration output therefore shows the new value one cycle after the write strobe, and a pointer or uniform index shows its advance on the same edge as the data write. Bus reads and core memory reads each pass through a single register, so their data is due one edge after the address. The bench drives every input on the falling edge and samples on the next falling edge, which lands exactly one rising edge after each stimulus. Uniform vectors are checked only after the write that completes them has been clocked in.

// File: rtl/shcfg_pkg.sv
package shcfg_pkg;
  localparam int WORD_W = 32;
  localparam int BUS_AW = 6;
  localparam int N_ALIAS = 8;
  localparam int N_INTU = 4;

  localparam logic [BUS_AW-1:0] A_BOOL  = 6'h00;
  localparam logic [BUS_AW-1:0] A_INT0  = 6'h01;
  localparam logic [BUS_AW-1:0] A_ENTRY = 6'h05;
  localparam logic [BUS_AW-1:0] A_MAPLO = 6'h06;
  localparam logic [BUS_AW-1:0] A_MAPHI = 6'h07;
  localparam logic [BUS_AW-1:0] A_OMASK = 6'h08;
  localparam logic [BUS_AW-1:0] A_ALAST = 6'h09;
  localparam logic [BUS_AW-1:0] A_USET  = 6'h0A;
  localparam logic [BUS_AW-1:0] A_UDAT  = 6'h0B;
  localparam logic [BUS_AW-1:0] A_PPTR  = 6'h13;
  localparam logic [BUS_AW-1:0] A_PDAT  = 6'h14;
  localparam logic [BUS_AW-1:0] A_SPTR  = 6'h1C;
  localparam logic [BUS_AW-1:0] A_SDAT  = 6'h1D;

  typedef enum logic {FMT_F24 = 1'b0, FMT_F32 = 1'b1} unif_fmt_e;

  function automatic logic in_alias(input logic [BUS_AW-1:0] a,
                                    input logic [BUS_AW-1:0] base);
    return (a >= base) && (a < base + BUS_AW'(N_ALIAS));
  endfunction
endpackage

// File: rtl/shcfg_upload_chan.sv
module shcfg_upload_chan #(
  parameter int DEPTH = 512,
  parameter int DW    = 32,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ptr_we,
  input  logic          data_we,
  input  logic [31:0]   wdata,
  output logic [31:0]   ptr_q,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) ptr_q <= '0;
    else if (ptr_we) ptr_q <= wdata;
    else if (data_we) ptr_q <= ptr_q + 32'd1;
  end

  always_ff @(posedge clk) begin
    if (data_we && !ptr_we) mem[ptr_q[AW-1:0]] <= wdata[DW-1:0];
    rd_data <= mem[rd_addr];
  end

  p_ptr_step_r10: assert property (@(posedge clk) disable iff (rst)
    (data_we && !ptr_we) |=> (ptr_q == $past(ptr_q) + 32'd1));
  p_ptr_load_r11: assert property (@(posedge clk) disable iff (rst)
    ptr_we |=> (ptr_q == $past(wdata)));
endmodule

// File: rtl/shcfg_unif_loader.sv
module shcfg_unif_loader
  import shcfg_pkg::*;
#(
  parameter int DEPTH = 128,
  localparam int IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          setup_we,
  input  logic          data_we,
  input  logic [31:0]   wdata,
  output logic [31:0]   setup_q,
  input  logic [IW-1:0] rd_addr,
  output logic [127:0]  rd_data
);
  logic [IW-1:0] idx_q;
  unif_fmt_e     fmt_q;
  logic [1:0]    cnt_q;
  logic [95:0]   buf_q;
  logic [1:0]    last_cnt;
  logic          take, done;
  logic [95:0]   packed24;
  logic [127:0]  vec;
  logic [127:0]  mem [DEPTH];

  assign last_cnt = (fmt_q == FMT_F32) ? 2'd3 : 2'd2;
  assign take     = data_we && !setup_we;
  assign done     = take && (cnt_q == last_cnt);
  assign packed24 = {buf_q[63:0], wdata};

  always_comb begin
    if (fmt_q == FMT_F32) vec = {buf_q, wdata};
    else vec = {8'h00, packed24[95:72], 8'h00, packed24[71:48],
                8'h00, packed24[47:24], 8'h00, packed24[23:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      fmt_q <= FMT_F24;
      cnt_q <= '0;
      buf_q <= '0;
    end else if (setup_we) begin
      idx_q <= wdata[IW-1:0];
      fmt_q <= unif_fmt_e'(wdata[31]);
      cnt_q <= '0;
    end else if (take) begin
      buf_q <= {buf_q[63:0], wdata};
      if (done) begin
        cnt_q <= '0;
        idx_q <= idx_q + 1'b1;
      end else begin
        cnt_q <= cnt_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (done) mem[idx_q] <= vec;
    rd_data <= mem[rd_addr];
  end

  assign setup_q = {fmt_q, {(31-IW){1'b0}}, idx_q};

  p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= last_cnt);
  p_idx_adv_r8: assert property (@(posedge clk) disable iff (rst)
    done |=> (idx_q == $past(idx_q) + 1'b1));
  p_setup_clr_r6: assert property (@(posedge clk) disable iff (rst)
    setup_we |=> (cnt_q == 2'd0));
endmodule

// File: rtl/shcfg_regfile.sv
module shcfg_regfile
  import shcfg_pkg::*;
#(
  parameter int PROG_DEPTH = 512,
  parameter int SWZ_DEPTH  = 128,
  parameter int UNIF_DEPTH = 128,
  localparam int PAW = $clog2(PROG_DEPTH),
  localparam int SAW = $clog2(SWZ_DEPTH),
  localparam int UAW = $clog2(UNIF_DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           bus_we,
  input  logic           bus_re,
  input  logic [5:0]     bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic [15:0]    bool_unif,
  output logic [127:0]   int_unif,
  output logic [15:0]    entry_off,
  output logic [63:0]    attr_map,
  output logic [3:0]     attr_last,
  output logic [15:0]    out_mask,
  input  logic [UAW-1:0] unif_raddr,
  output logic [127:0]   unif_rdata,
  input  logic [PAW-1:0] prog_raddr,
  output logic [31:0]    prog_rdata,
  input  logic [SAW-1:0] swz_raddr,
  output logic [31:0]    swz_rdata
);
  logic [31:0] int_q [N_INTU];
  logic [31:0] uset_q, pptr_q, sptr_q;
  logic [31:0] rd_mux;
  logic        wr_uset, wr_udat, wr_pptr, wr_pdat, wr_sptr, wr_sdat;

  assign wr_uset = bus_we && (bus_addr == A_USET);
  assign wr_udat = bus_we && in_alias(bus_addr, A_UDAT);
  assign wr_pptr = bus_we && (bus_addr == A_PPTR);
  assign wr_pdat = bus_we && in_alias(bus_addr, A_PDAT);
  assign wr_sptr = bus_we && (bus_addr == A_SPTR);
  assign wr_sdat = bus_we && in_alias(bus_addr, A_SDAT);

  always_ff @(posedge clk) begin
    if (rst) begin
      bool_unif <= '0;
      entry_off <= '0;
      attr_map  <= '0;
      attr_last <= '0;
      out_mask  <= '0;
      for (int i = 0; i < N_INTU; i++) int_q[i] <= '0;
    end else if (bus_we) begin
      case (bus_addr)
        A_BOOL:  bool_unif <= bus_wdata[15:0];
        A_ENTRY: entry_off <= bus_wdata[15:0];
        A_MAPLO: attr_map[31:0] <= bus_wdata;
        A_MAPHI: attr_map[63:32] <= bus_wdata;
        A_OMASK: out_mask <= bus_wdata[15:0];
        A_ALAST: attr_last <= bus_wdata[3:0];
        default: ;
      endcase
      for (int i = 0; i < N_INTU; i++)
        if (bus_addr == A_INT0 + BUS_AW'(i)) int_q[i] <= bus_wdata;
    end
  end

  for (genvar g = 0; g < N_INTU; g++) begin : g_intpack
    assign int_unif[32*g +: 32] = int_q[g];
  end

  shcfg_unif_loader #(.DEPTH(UNIF_DEPTH)) u_unif (
    .clk(clk), .rst(rst), .setup_we(wr_uset), .data_we(wr_udat),
    .wdata(bus_wdata), .setup_q(uset_q), .rd_addr(unif_raddr),
    .rd_data(unif_rdata));

  shcfg_upload_chan #(.DEPTH(PROG_DEPTH), .DW(32)) u_prog (
    .clk(clk), .rst(rst), .ptr_we(wr_pptr), .data_we(wr_pdat),
    .wdata(bus_wdata), .ptr_q(pptr_q), .rd_addr(prog_raddr),
    .rd_data(prog_rdata));

  shcfg_upload_chan #(.DEPTH(SWZ_DEPTH), .DW(32)) u_swz (
    .clk(clk), .rst(rst), .ptr_we(wr_sptr), .data_we(wr_sdat),
    .wdata(bus_wdata), .ptr_q(sptr_q), .rd_addr(swz_raddr),
    .rd_data(swz_rdata));

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_BOOL:  rd_mux = {16'h0, bool_unif};
      A_ENTRY: rd_mux = {16'h0, entry_off};
      A_MAPLO: rd_mux = attr_map[31:0];
      A_MAPHI: rd_mux = attr_map[63:32];
      A_OMASK: rd_mux = {16'h0, out_mask};
      A_ALAST: rd_mux = {28'h0, attr_last};
      A_USET:  rd_mux = uset_q;
      A_PPTR:  rd_mux = pptr_q;
      A_SPTR:  rd_mux = sptr_q;
      default: ;
    endcase
    for (int i = 0; i < N_INTU; i++)
      if (bus_addr == A_INT0 + BUS_AW'(i)) rd_mux = int_q[i];
  end

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else if (bus_re) bus_rdata <= rd_mux;
  end

  p_alias_rd_zero_r12: assert property (@(posedge clk) disable iff (rst)
    (bus_re && (in_alias(bus_addr, A_UDAT) || in_alias(bus_addr, A_PDAT) ||
     in_alias(bus_addr, A_SDAT) || bus_addr > 6'h24)) |=> (bus_rdata == 32'h0));
  p_rd_hold_r13: assert property (@(posedge clk) disable iff (rst)
    !bus_re |=> $stable(bus_rdata));
endmodule

// File: tb/shcfg_regfile_tb_top.sv
module shcfg_regfile_tb_top;
  logic clk = 1'b0;
  logic rst, bus_we, bus_re;
  logic [5:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [15:0] bool_unif, entry_off, out_mask;
  logic [127:0] int_unif, unif_rdata;
  logic [63:0] attr_map;
  logic [3:0] attr_last;
  logic [6:0] unif_raddr, swz_raddr;
  logic [8:0] prog_raddr;
  logic [31:0] prog_rdata, swz_rdata;
  int checks = 0, fails = 0;
  bit done_flag = 1'b0;

  always #2.5 clk = ~clk;

  shcfg_regfile dut_i (.*);

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_we = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); bus_re = 1'b1; bus_addr = a;
    @(negedge clk); bus_re = 1'b0; d = bus_rdata;
  endtask

  task automatic rd_unif(input logic [6:0] a, output logic [127:0] d);
    @(negedge clk); unif_raddr = a; @(negedge clk); d = unif_rdata;
  endtask
  task automatic rd_prog(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk); prog_raddr = a; @(negedge clk); d = prog_rdata;
  endtask
  task automatic rd_swz(input logic [6:0] a, output logic [31:0] d);
    @(negedge clk); swz_raddr = a; @(negedge clk); d = swz_rdata;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd(6'h00, d); chk("R1 bool reset", d, 0);
    rd(6'h13, d); chk("R1 prog ptr reset", d, 0);
    rd(6'h0A, d); chk("R1 setup reset", d, 0);
    chk("R1 outputs reset", {bool_unif, entry_off, attr_last}, 0);
  endtask

  task automatic t_plain;
    logic [31:0] d;
    wr(6'h00, 32'hFFFF_ABCD);
    rd(6'h00, d); chk("R2 bool readback", d, 32'h0000_ABCD);
    chk("R2 bool out", bool_unif, 16'hABCD);
    wr(6'h03, 32'h4433_2211);
    rd(6'h03, d); chk("R3 int2 readback", d, 32'h4433_2211);
    chk("R3 int2 y field", int_unif[2*32+8 +: 8], 8'h22);
    chk("R3 int2 w field", int_unif[2*32+24 +: 8], 8'h44);
    wr(6'h05, 32'h1234_5678);
    rd(6'h05, d); chk("R4 entry", d, 32'h0000_5678);
    wr(6'h08, 32'hDEAD_BEEF);
    rd(6'h08, d); chk("R4 mask", d, 32'h0000_BEEF);
    wr(6'h09, 32'h0000_00FF);
    rd(6'h09, d); chk("R4 attr last", d, 32'hF);
    wr(6'h06, 32'h7654_3210); wr(6'h07, 32'hFEDC_BA98);
    chk("R5 attr map", attr_map, 64'hFEDC_BA98_7654_3210);
    rd(6'h07, d); chk("R5 map hi read", d, 32'hFEDC_BA98);
  endtask

  task automatic t_fp32;
    logic [31:0] d; logic [127:0] v;
    wr(6'h0A, 32'h8000_0005);
    wr(6'h0B, 32'hAAAA_0001); wr(6'h0E, 32'hBBBB_0002);
    wr(6'h12, 32'hCCCC_0003); wr(6'h0C, 32'hDDDD_0004);
    rd(6'h0A, d); chk("R7 index advanced", d, 32'h8000_0006);
    rd_unif(7'd5, v);
    chk("R7 R9 fp32 vector", v, 128'hAAAA_0001_BBBB_0002_CCCC_0003_DDDD_0004);
    wr(6'h0A, 32'h8000_0010);
    wr(6'h0B, 32'h1111_1111); wr(6'h0B, 32'h2222_2222);
    wr(6'h0A, 32'h8000_0010);
    rd(6'h0A, d); chk("R6 setup no advance", d, 32'h8000_0010);
    wr(6'h0B, 32'h0000_00A0); wr(6'h0B, 32'h0000_00B0);
    wr(6'h0B, 32'h0000_00C0); wr(6'h0B, 32'h0000_00D0);
    rd_unif(7'h10, v);
    chk("R6 partial discarded", v, 128'h0000_00A0_0000_00B0_0000_00C0_0000_00D0);
  endtask

  task automatic t_fp24;
    logic [31:0] d; logic [127:0] v;
    wr(6'h0A, 32'h0000_0007);
    wr(6'h0B, 32'h1122_3344); wr(6'h0D, 32'h5566_7788); wr(6'h11, 32'h99AA_BBCC);
    rd(6'h0A, d); chk("R8 index advanced", d, 32'h0000_0008);
    rd_unif(7'd7, v);
    chk("R8 fp24 unpack", v, 128'h0011_2233_0044_5566_0077_8899_00AA_BBCC);
    wr(6'h0A, 32'h0000_007F);
    wr(6'h0B, 32'h0); wr(6'h0B, 32'h0); wr(6'h0B, 32'h1);
    rd(6'h0A, d); chk("R8 index wrap", d, 32'h0);
  endtask

  task automatic t_prog;
    logic [31:0] d;
    wr(6'h13, 32'd10);
    wr(6'h14, 32'hC0DE_0000); wr(6'h17, 32'hC0DE_0001); wr(6'h1B, 32'hC0DE_0002);
    rd(6'h13, d); chk("R10 ptr advance", d, 32'd13);
    rd_prog(9'd10, d); chk("R10 word0", d, 32'hC0DE_0000);
    rd_prog(9'd12, d); chk("R10 R9 word2", d, 32'hC0DE_0002);
    wr(6'h13, 32'd511);
    wr(6'h15, 32'h5151_5151); wr(6'h15, 32'h0F0F_0F0F);
    rd(6'h13, d); chk("R10 ptr full width", d, 32'd513);
    rd_prog(9'd511, d); chk("R10 last word", d, 32'h5151_5151);
    rd_prog(9'd0, d); chk("R10 wrap word", d, 32'h0F0F_0F0F);
  endtask

  task automatic t_swz;
    logic [31:0] d;
    wr(6'h1C, 32'd127);
    wr(6'h1D, 32'h0000_ABCD); wr(6'h24, 32'h0000_1234);
    rd(6'h1C, d); chk("R11 ptr", d, 32'd129);
    rd_swz(7'd127, d); chk("R11 last entry", d, 32'h0000_ABCD);
    rd_swz(7'd0, d); chk("R11 wrap entry", d, 32'h0000_1234);
  endtask

  task automatic t_misc;
    logic [31:0] d;
    rd(6'h16, d); chk("R12 alias reads zero", d, 32'h0);
    rd(6'h0F, d); chk("R12 uniform alias zero", d, 32'h0);
    wr(6'h2F, 32'hFFFF_FFFF);
    rd(6'h2F, d); chk("R12 reserved zero", d, 32'h0);
    rd(6'h00, d); chk("R12 reserved write no effect", d, 32'h0000_ABCD);
    @(negedge clk); bus_re = 1'b1; bus_addr = 6'h05;
    @(posedge clk); #1 chk("R13 read one cycle", bus_rdata, 32'h0000_5678);
    @(negedge clk); bus_re = 1'b0;
  endtask

  initial begin
    rst = 1'b1; bus_we = 0; bus_re = 0; bus_addr = 0; bus_wdata = 0;
    unif_raddr = 0; prog_raddr = 0; swz_raddr = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset; t_plain; t_fp32; t_fp24; t_prog; t_swz; t_misc;
    done_flag = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done_flag) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule